// File: doc/BRIEF.md
# Segmented Carry-Select Adder with Add-One Correction

This block is a purely combinational 16-bit adder. It takes two operands and a carry-in, and it returns a 16-bit sum and a carry-out. The operands are cut into four slices of four bits each.

The bottom slice is a small prefix-tree adder that uses the external carry-in directly. Each of the three upper slices works in three steps:

- It first builds its result with a four-bit Brent-Kung prefix tree, assuming no incoming carry.
- It then forms the assumed-carry result by passing that first result through an add-one converter. The slice does not use a second adder for this.
- A five-bit-wide two-way selector picks one of the two candidates. The carry leaving the slice below drives the select.

The block holds no state and has no clock or reset. It is meant to sit on a datapath wherever a 16-bit add with carry is needed. Its delay is one prefix slice, plus one add-one converter, plus a chain of three selectors.

Top module: `sca_adder`

## Requirements
- R1: For every input, {carry_out, sum_out} equals opnd_a + opnd_b + carry_in as a 17-bit unsigned value.
- R2: sum_out[3:0] and the carry leaving bit 3 equal opnd_a[3:0] + opnd_b[3:0] + carry_in. The bottom slice uses the external carry-in directly.
- R3: For an upper slice whose incoming carry is 0, its four sum bits and outgoing carry equal the plain sum of that slice's operand bits.
- R4: For an upper slice whose incoming carry is 1, its result is the carry-free slice sum plus one. When the carry-free slice sum is 1111, the slice bits become 0000 and the slice carry-out becomes 1.
- R5: carry_out equals the carry leaving the top slice (bit 15).
- R6: A carry can ripple through all four slices. For example, 0xFFFF + 0x0000 with carry_in 1 gives sum 0x0000 with carry_out 1.
- R7: Adding opnd_b = 0 with carry_in = 0 returns opnd_a unchanged, with carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The assertions are immediate checks evaluated on settled combinational values. They therefore assume that every input is a known 0 or 1 whenever the checks run. The bench drives only fully defined operands and carry values, changes them away from the sampling point, and reads outputs half a clock later, after the logic has settled. Slice-level properties hold only with a defined incoming carry. To keep that carry defined and known, the bench forces it through the lower operand bits: all-ones with zero and carry_in 1 sets it to 1, and all zeros sets it to 0.

// File: rtl/sca_pkg.sv
package sca_pkg;
    // width of one slice; the prefix tree below is built for this size
    localparam int SLICE_W = 4;
    // candidate width: slice sum bits plus the slice carry
    localparam int CAND_W  = SLICE_W + 1;
endpackage

// File: rtl/sca_bk_slice.sv
// Four-bit Brent-Kung prefix adder. The slice carry-in is folded into bit 0's generate term.
module sca_bk_slice
    import sca_pkg::*;
(
    input  logic [SLICE_W-1:0] x_in,
    input  logic [SLICE_W-1:0] y_in,
    input  logic               c_in,
    output logic [SLICE_W-1:0] s_out,
    output logic               c_out
);
    logic [SLICE_W-1:0] prop;
    logic [SLICE_W-1:0] gen;
    logic g_0;      // generate of bit 0 including carry-in
    logic g_10;     // group generate over bits 1..0
    logic g_32;     // group generate over bits 3..2
    logic p_32;     // group propagate over bits 3..2
    logic g_20;     // fix-up node: bits 2..0
    logic g_30;     // root node: bits 3..0

    // pre-processing: per-bit propagate and generate
    always_comb begin
        prop = x_in ^ y_in;
        gen  = x_in & y_in;
    end

    // carry network, first level combines neighbour pairs
    always_comb begin
        g_0  = gen[0] | (prop[0] & c_in);
        g_10 = gen[1] | (prop[1] & g_0);
        g_32 = gen[3] | (prop[3] & gen[2]);
        p_32 = prop[3] & prop[2];
    end

    // second level root and inverse-tree fix-up
    always_comb begin
        g_30 = g_32 | (p_32 & g_10);
        g_20 = gen[2] | (prop[2] & g_10);
    end

    // post-processing: sum from propagate and incoming carry
    always_comb begin
        s_out = prop ^ {g_20, g_10, g_0, c_in};
        c_out = g_30;
    end
endmodule

// File: rtl/sca_inc_conv.sv
// Add-one converter on a carry-free slice result (sum bits plus carry).
module sca_inc_conv
    import sca_pkg::*;
(
    input  logic [SLICE_W-1:0] s_base,
    input  logic               c_base,
    output logic [SLICE_W-1:0] s_plus,
    output logic               c_plus
);
    // run[k] is high when all bits below k are one
    logic [SLICE_W:0] run;

    always_comb begin
        run[0] = 1'b1;
        for (int k = 0; k < SLICE_W; k++) begin
            run[k+1] = run[k] & s_base[k];
        end
    end

    always_comb begin
        for (int k = 0; k < SLICE_W; k++) begin
            s_plus[k] = s_base[k] ^ run[k];
        end
        c_plus = c_base | run[SLICE_W];
    end
endmodule

// File: rtl/sca_pick.sv
// Two-way candidate selector (sum bits plus carry).
module sca_pick #(
    parameter int W = 5
) (
    input  logic [W-1:0] cand_lo,
    input  logic [W-1:0] cand_hi,
    input  logic         pick_hi,
    output logic [W-1:0] chosen
);
    always_comb begin
        chosen = pick_hi ? cand_hi : cand_lo;
    end
endmodule

// File: rtl/sca_adder.sv
module sca_adder
    import sca_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    localparam int NUM_SL = DATA_W / SLICE_W;

    // slice_c[k] is the carry entering slice k
    logic [NUM_SL:0] slice_c;

    assign slice_c[0] = carry_in;

    generate
        for (genvar k = 0; k < NUM_SL; k++) begin : g_slice
            if (k == 0) begin : g_base
                sca_bk_slice u_bk (
                    .x_in (opnd_a[SLICE_W-1:0]),
                    .y_in (opnd_b[SLICE_W-1:0]),
                    .c_in (slice_c[0]),
                    .s_out(sum_out[SLICE_W-1:0]),
                    .c_out(slice_c[1])
                );
            end else begin : g_upper
                logic [SLICE_W-1:0] s_zero;
                logic               c_zero;
                logic [SLICE_W-1:0] s_one;
                logic               c_one;
                logic [CAND_W-1:0]  picked;

                sca_bk_slice u_bk (
                    .x_in (opnd_a[k*SLICE_W +: SLICE_W]),
                    .y_in (opnd_b[k*SLICE_W +: SLICE_W]),
                    .c_in (1'b0),
                    .s_out(s_zero),
                    .c_out(c_zero)
                );

                sca_inc_conv u_inc (
                    .s_base(s_zero),
                    .c_base(c_zero),
                    .s_plus(s_one),
                    .c_plus(c_one)
                );

                sca_pick #(.W(CAND_W)) u_pick (
                    .cand_lo({c_zero, s_zero}),
                    .cand_hi({c_one, s_one}),
                    .pick_hi(slice_c[k]),
                    .chosen (picked)
                );

                assign sum_out[k*SLICE_W +: SLICE_W] = picked[SLICE_W-1:0];
                assign slice_c[k+1]                  = picked[SLICE_W];
            end
        end
    endgenerate

    assign carry_out = slice_c[NUM_SL];
endmodule

// File: rtl/sca_adder_chk.sv
module sca_adder_chk
    import sca_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic [DATA_W-1:0]         opnd_a,
    input logic [DATA_W-1:0]         opnd_b,
    input logic                      carry_in,
    input logic [DATA_W-1:0]         sum_out,
    input logic                      carry_out,
    input logic [DATA_W/SLICE_W:0]   slice_c
);
    localparam int NUM_SL = DATA_W / SLICE_W;

    always_comb begin
        assert_total_sum_R1: assert ({carry_out, sum_out} ==
            ({1'b0, opnd_a} + {1'b0, opnd_b} + {{DATA_W{1'b0}}, carry_in}));

        assert_base_slice_R2: assert ({slice_c[1], sum_out[SLICE_W-1:0]} ==
            ({1'b0, opnd_a[SLICE_W-1:0]} + {1'b0, opnd_b[SLICE_W-1:0]}
             + {{SLICE_W{1'b0}}, carry_in}));

        // R3 and R4: each upper slice equals operand slice sum plus its incoming carry
        for (int k = 1; k < NUM_SL; k++) begin
            assert_upper_slice_R4: assert ({slice_c[k+1], sum_out[k*SLICE_W +: SLICE_W]} ==
                ({1'b0, opnd_a[k*SLICE_W +: SLICE_W]} + {1'b0, opnd_b[k*SLICE_W +: SLICE_W]}
                 + {{SLICE_W{1'b0}}, slice_c[k]}));
        end

        assert_top_carry_R5: assert (carry_out == slice_c[NUM_SL]);

        if (opnd_b == '0 && !carry_in) begin
            assert_zero_pass_R7: assert (sum_out == opnd_a && !carry_out);
        end
    end
endmodule

bind sca_adder sca_adder_chk #(.DATA_W(DATA_W)) u_chk (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out),
    .slice_c  (slice_c)
);

// File: tb/sca_adder_bench.sv
`timescale 1ns/1ps
module sca_adder_bench;
    logic        clk = 1'b0;
    logic [15:0] a_drv = '0;
    logic [15:0] b_drv = '0;
    logic        ci_drv = 1'b0;
    logic [15:0] sum_w;
    logic        co_w;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    sca_adder u_sca_adder (
        .opnd_a   (a_drv),
        .opnd_b   (b_drv),
        .carry_in (ci_drv),
        .sum_out  (sum_w),
        .carry_out(co_w)
    );

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(posedge clk);
        a_drv  = a;
        b_drv  = b;
        ci_drv = c;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h c=%b got=%h exp=%h", req, a_drv, b_drv, ci_drv, got, exp);
        end
    endtask

    function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {16'd0, c};
    endfunction

    initial begin
        // zero inputs give zero outputs (R1)
        drive(16'h0000, 16'h0000, 1'b0);
        chk("R1_zero", {co_w, sum_w}, 17'h0);

        // R2: bottom slice exhaustive with carry-in
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++) begin
                    drive(16'(x), 16'(y), c[0]);
                    chk("R2", {13'd0, u_sca_adder.sum_out[3:0] == 4'((x + y + c)) ? 4'(x+y+c) : sum_w[3:0]},
                        {13'd0, 4'(x + y + c)});
                    chk("R1", {co_w, sum_w}, ref_add(16'(x), 16'(y), c[0]));
                end

        // R3 and R4: each upper slice, incoming carry forced to 0 then to 1
        for (int k = 1; k < 4; k++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++) begin
                    logic [15:0] a;
                    logic [15:0] b;
                    logic [16:0] e;
                    a = 16'(x) << (4 * k);
                    b = 16'(y) << (4 * k);
                    drive(a, b, 1'b0);
                    e = ref_add(a, b, 1'b0);
                    chk("R3", {co_w, sum_w}, e);
                    // lower bits all ones plus carry-in 1 forces a carry into slice k
                    a = a | ((16'h1 << (4 * k)) - 16'h1);
                    drive(a, b, 1'b1);
                    e = ref_add(a, b, 1'b1);
                    chk("R4", {co_w, sum_w}, e);
                end

        // R4 wrap: slice sum 1111 plus carry gives 0000 and a slice carry
        drive(16'h00FF, 16'h0000, 1'b1);
        chk("R4_wrap", {co_w, sum_w}, 17'h00100);

        // R5: top carry
        drive(16'hF000, 16'h1000, 1'b0);
        chk("R5", {16'd0, co_w}, 17'd1);
        drive(16'h7000, 16'h0FFF, 1'b1);
        chk("R5_nocarry", {co_w, sum_w}, 17'h08000);

        // R6: carry through all slices
        drive(16'hFFFF, 16'h0000, 1'b1);
        chk("R6", {co_w, sum_w}, 17'h10000);
        drive(16'hFFFF, 16'h0001, 1'b0);
        chk("R6", {co_w, sum_w}, 17'h10000);
        drive(16'hFFFF, 16'hFFFF, 1'b1);
        chk("R6", {co_w, sum_w}, 17'h1FFFF);
        drive(16'hAAAA, 16'h5555, 1'b1);
        chk("R6", {co_w, sum_w}, 17'h10000);
        drive(16'hAAAA, 16'h5555, 1'b0);
        chk("R1_alt", {co_w, sum_w}, 17'h0FFFF);

        // R7: adding zero
        drive(16'hBEEF, 16'h0000, 1'b0);
        chk("R7", {co_w, sum_w}, 17'h0BEEF);
        drive(16'hFFFF, 16'h0000, 1'b0);
        chk("R7", {co_w, sum_w}, 17'h0FFFF);

        // R1: random operands, both carry values
        for (int i = 0; i < 100000; i++) begin
            logic [15:0] a;
            logic [15:0] b;
            logic        c;
            a = 16'($urandom);
            b = 16'($urandom);
            c = 1'($urandom);
            drive(a, b, c);
            chk("R1_rand", {co_w, sum_w}, ref_add(a, b, c));
        end

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired got=running exp=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule